// File: doc/BRIEF.md
# Four-Bit Accumulator Processor Datapath

This block is the datapath of a very small accumulator machine. An external microsequencer supplies a 13-bit control word every clock cycle. The datapath holds a program counter, an instruction register, an operand register, a 4-bit accumulator with zero and carry flags, and a 16-word by 4-bit program store that is read-only and filled from a parameter. It returns the current opcode and both flags to the sequencer, and it drives the accumulator on a 4-bit result port.

An instruction is fetched by loading the instruction register from the word the program counter points at. A two-word instruction then loads its second word, a direct address, into the operand register. The sequencer addresses the program store through the operand register and writes the ALU result into the accumulator. A jump copies the operand register into the program counter, and the sequencer decides from the reported flags whether to issue that copy. Nothing writes back to the program store.

The opcode values the sequencer decodes are: load 0x8, add 0x9, subtract 0xA, jump-if-zero 0xB, jump-if-carry 0xC, AND 0xD, complement 0x0, increment 0x2, decrement 0x4 and halt 0x6. All ports are plain control and status pins. No port streams data, so there is no valid/ready handshake and no back-pressure.

Top module: `acc4_datapath`

## Requirements
- R1: When `rst` is high at a rising edge (synchronous reset), the program counter, instruction register, operand register, accumulator, zero flag and carry flag all become 0 at that edge.
- R2: Each read of the program store is combinational. By default, word i holds (7*i+3) mod 16. ctl[2] loads the instruction register from the word the program store drives, and `opcode` shows the instruction register. ctl[12] clears the instruction register and takes priority over ctl[2]. The instruction register holds its value while neither bit is set.
- R3: The program counter obeys these bits in priority order: ctl[9] clears it to 0, ctl[1] copies the operand register into it, and ctl[0] increments it, wrapping from 15 to 0.
- R4: ctl[3] loads the operand register from the word the program store drives. ctl[4] picks the program store address: 0 selects the program counter and 1 selects the operand register. ctl[5] writes the ALU result, with the operation chosen by ctl[8:6]. Code 0 loads the addressed word M and leaves the carry flag unchanged.
- R5: Code 1 adds, A := A+M. The carry flag takes the carry out of bit 3.
- R6: Code 2 subtracts, computed as A+~M+1. The carry flag takes the carry out, so 1 means no borrow.
- R7: Code 3 performs A := A AND M and code 4 performs A := ~A. Code 7 rewrites A unchanged. All three leave the carry flag unchanged.
- R8: Code 5 increments A and code 6 decrements A, computed as A+0xF. The carry flag takes the carry out, so it is 1 after incrementing 15 and 1 after decrementing any nonzero value.
- R9: Each accumulator write (ctl[5] or ctl[10]) recomputes the zero flag, which is 1 when the new accumulator value is 0. This holds unless ctl[11] is also set.
- R10: While neither ctl[5] nor ctl[10] is set, the accumulator keeps its value.
- R11: ctl[10] clears the accumulator and takes priority over ctl[5]. ctl[11] clears both flags and takes priority over every other flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctl | input | 13 | Control word from the sequencer; bit map in R2 to R11 |
| opcode | output | 4 | Instruction register contents |
| zero | output | 1 | Zero flag |
| carry | output | 1 | Carry flag (1 = no borrow after subtract or decrement) |
| acc_out | output | 4 | Accumulator |

## Verification
The assertions assume that `ctl` is stable around each rising edge and that it is a legal combination. In particular, a fetch or an operand load is issued with ctl[4] low, so the word comes from the program counter's address, and flag updates are judged only against the priority order in R11. The bench drives `ctl` only at falling edges, and it does so through a few tasks that each assemble one legal control word. The program store is a permutation of 0 to 15, so walking the program counter to every position reaches every accumulator value and every operand value. This makes the add, subtract and AND sweeps exhaustive over both operands.

// File: rtl/acc4_pkg.sv
package acc4_pkg;

  localparam int DW_DEF = 4;
  localparam int AW_DEF = 4;
  localparam int CTL_W  = 13;

  // control word bit positions
  localparam int CB_PC_INC  = 0;
  localparam int CB_PC_LD   = 1;
  localparam int CB_IR_LD   = 2;
  localparam int CB_OPR_LD  = 3;
  localparam int CB_ADR_SEL = 4;
  localparam int CB_ACC_WE  = 5;
  localparam int CB_OP_LO   = 6;
  localparam int CB_OP_HI   = 8;
  localparam int CB_PC_CLR  = 9;
  localparam int CB_ACC_CLR = 10;
  localparam int CB_FLG_CLR = 11;
  localparam int CB_IR_CLR  = 12;

  typedef enum logic [2:0] {
    ALU_LOAD = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_SUB  = 3'd2,
    ALU_AND  = 3'd3,
    ALU_CMP  = 3'd4,
    ALU_INC  = 3'd5,
    ALU_DEC  = 3'd6,
    ALU_KEEP = 3'd7
  } alu_op_e;

  // instruction opcodes, decoded by the sequencer
  typedef enum logic [3:0] {
    OPC_CMA = 4'h0,
    OPC_INC = 4'h2,
    OPC_DEC = 4'h4,
    OPC_HLT = 4'h6,
    OPC_LDA = 4'h8,
    OPC_ADD = 4'h9,
    OPC_SUB = 4'hA,
    OPC_JZ  = 4'hB,
    OPC_JC  = 4'hC,
    OPC_AND = 4'hD
  } opcode_e;

  // default program image: word i = (7*i+3) mod 16
  function automatic logic [(1<<AW_DEF)*DW_DEF-1:0] default_image();
    logic [(1<<AW_DEF)*DW_DEF-1:0] img;
    img = '0;
    for (int i = 0; i < (1 << AW_DEF); i++) begin
      img[i*DW_DEF +: DW_DEF] = DW_DEF'((7 * i + 3) % (1 << DW_DEF));
    end
    return img;
  endfunction

endpackage

// File: rtl/acc4_prog_rom.sv
module acc4_prog_rom #(
  parameter int DW = 4,
  parameter int AW = 4,
  parameter logic [(1<<AW)*DW-1:0] IMAGE = '0
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    assign words[gi] = IMAGE[gi*DW +: DW];
  end

  assign q = words[addr];
endmodule

// File: rtl/acc4_seq_regs.sv
module acc4_seq_regs #(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pc_clr,
  input  logic          pc_ld,
  input  logic          pc_inc,
  input  logic          ir_clr,
  input  logic          ir_ld,
  input  logic          opr_ld,
  input  logic [DW-1:0] rom_q,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] opr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (pc_clr) begin
      pc <= '0;
    end else if (pc_ld) begin
      pc <= opr;
    end else if (pc_inc) begin
      pc <= pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ir_clr) begin
      ir <= '0;
    end else if (ir_ld) begin
      ir <= rom_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opr <= '0;
    end else if (opr_ld) begin
      opr <= AW'(rom_q);
    end
  end

  // R3: plain increment advances by one, wrapping at the top
  p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!pc_clr && !pc_ld && pc_inc) |=> (pc == AW'($past(pc) + 1'b1)));

  // R3: clear beats every other program counter request
  p_pc_clear_r3: assert property (@(posedge clk) disable iff (rst)
    pc_clr |=> (pc == '0));

  // R2: instruction register untouched without a request
  p_ir_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!ir_ld && !ir_clr) |=> $stable(ir));
endmodule

// File: rtl/acc4_alu.sv
module acc4_alu
  import acc4_pkg::*;
#(
  parameter int DW = 4
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  output logic [DW-1:0] r,
  output logic          cout,
  output logic          c_upd
);
  logic [DW-1:0] b;
  logic          cin;
  logic [DW-1:0] sum;
  logic [DW:0]   cy;

  // operand shaping for the shared adder
  always_comb begin
    b   = '0;
    cin = 1'b0;
    unique case (op)
      ALU_ADD: begin b = m;           cin = 1'b0; end
      ALU_SUB: begin b = ~m;          cin = 1'b1; end
      ALU_INC: begin b = '0;          cin = 1'b1; end
      ALU_DEC: begin b = '1;          cin = 1'b0; end
      default: begin b = '0;          cin = 1'b0; end
    endcase
  end

  assign cy[0] = cin;
  for (genvar gi = 0; gi < DW; gi++) begin : g_fa
    assign sum[gi]   = a[gi] ^ b[gi] ^ cy[gi];
    assign cy[gi+1]  = (a[gi] & b[gi]) | (cy[gi] & (a[gi] ^ b[gi]));
  end

  always_comb begin
    r     = a;
    c_upd = 1'b0;
    unique case (op)
      ALU_LOAD: r = m;
      ALU_AND:  r = a & m;
      ALU_CMP:  r = ~a;
      ALU_KEEP: r = a;
      ALU_ADD, ALU_SUB, ALU_INC, ALU_DEC: begin
        r     = sum;
        c_upd = 1'b1;
      end
      default:  r = a;
    endcase
  end

  assign cout = cy[DW];
endmodule

// File: rtl/acc4_acc_regs.sv
module acc4_acc_regs #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_we,
  input  logic          acc_clr,
  input  logic          flg_clr,
  input  logic          logic_op,
  input  logic [DW-1:0] alu_r,
  input  logic          alu_c,
  input  logic          c_upd,
  output logic [DW-1:0] acc,
  output logic          z,
  output logic          c
);
  always_ff @(posedge clk) begin
    if (rst || acc_clr) begin
      acc <= '0;
    end else if (acc_we) begin
      acc <= alu_r;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flg_clr) begin
      z <= 1'b0;
      c <= 1'b0;
    end else begin
      if (acc_clr) begin
        z <= 1'b1;
      end else if (acc_we) begin
        z <= (alu_r == '0);
      end
      if (acc_we && !acc_clr && c_upd) begin
        c <= alu_c;
      end
    end
  end

  // R9: zero flag agrees with the freshly written accumulator
  p_zero_follow_r9: assert property (@(posedge clk) disable iff (rst)
    ((acc_we || acc_clr) && !flg_clr) |=> (z == (acc == '0)));

  // R10: accumulator holds without a write
  p_acc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!acc_we && !acc_clr) |=> $stable(acc));

  // R7: logic operations never disturb carry
  p_carry_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_we && logic_op && !flg_clr) |=> $stable(c));

  // R11: flag clear wins
  p_flag_clear_r11: assert property (@(posedge clk) disable iff (rst)
    flg_clr |=> (!z && !c));
endmodule

// File: rtl/acc4_datapath.sv
module acc4_datapath
  import acc4_pkg::*;
#(
  parameter int DW = DW_DEF,
  parameter int AW = AW_DEF,
  parameter logic [(1<<AW)*DW-1:0] ROM_IMAGE = default_image()
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTL_W-1:0]  ctl,
  output logic [DW-1:0]     opcode,
  output logic              zero,
  output logic              carry,
  output logic [DW-1:0]     acc_out
);
  logic [AW-1:0] pc;
  logic [AW-1:0] opr;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_q;
  logic [DW-1:0] ir;
  logic [DW-1:0] acc;
  logic [DW-1:0] alu_r;
  logic          alu_c;
  logic          c_upd;
  logic          z;
  logic          c;
  alu_op_e       op;
  logic          logic_op;

  assign op       = alu_op_e'(ctl[CB_OP_HI:CB_OP_LO]);
  assign logic_op = (op == ALU_LOAD) || (op == ALU_AND) ||
                    (op == ALU_CMP)  || (op == ALU_KEEP);
  assign rom_addr = ctl[CB_ADR_SEL] ? opr : pc;

  acc4_seq_regs #(.DW(DW), .AW(AW)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .pc_clr (ctl[CB_PC_CLR]),
    .pc_ld  (ctl[CB_PC_LD]),
    .pc_inc (ctl[CB_PC_INC]),
    .ir_clr (ctl[CB_IR_CLR]),
    .ir_ld  (ctl[CB_IR_LD]),
    .opr_ld (ctl[CB_OPR_LD]),
    .rom_q  (rom_q),
    .pc     (pc),
    .ir     (ir),
    .opr    (opr)
  );

  acc4_prog_rom #(.DW(DW), .AW(AW), .IMAGE(ROM_IMAGE)) u_rom (
    .addr (rom_addr),
    .q    (rom_q)
  );

  acc4_alu #(.DW(DW)) u_alu (
    .op    (op),
    .a     (acc),
    .m     (rom_q),
    .r     (alu_r),
    .cout  (alu_c),
    .c_upd (c_upd)
  );

  acc4_acc_regs #(.DW(DW)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .acc_we   (ctl[CB_ACC_WE]),
    .acc_clr  (ctl[CB_ACC_CLR]),
    .flg_clr  (ctl[CB_FLG_CLR]),
    .logic_op (logic_op),
    .alu_r    (alu_r),
    .alu_c    (alu_c),
    .c_upd    (c_upd),
    .acc      (acc),
    .z        (z),
    .c        (c)
  );

  assign opcode  = ir;
  assign zero    = z;
  assign carry   = c;
  assign acc_out = acc;

  // R1: reset leaves every visible register cleared
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && !zero && !carry && opcode == '0));

  // R6: subtracting the value just loaded from itself yields zero, no borrow
  p_sub_self_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl[CB_ACC_WE] && !ctl[CB_ACC_CLR] && !ctl[CB_FLG_CLR] &&
     op == ALU_SUB && rom_q == acc) |=> (acc_out == '0 && zero && carry));
endmodule

// File: tb/acc4_datapath_tb.sv
module acc4_datapath_tb;
  localparam int PC_INC  = 1 << 0;
  localparam int PC_LD   = 1 << 1;
  localparam int IR_LD   = 1 << 2;
  localparam int OPR_LD  = 1 << 3;
  localparam int ADR_SEL = 1 << 4;
  localparam int ACC_WE  = 1 << 5;
  localparam int PC_CLR  = 1 << 9;
  localparam int ACC_CLR = 1 << 10;
  localparam int FLG_CLR = 1 << 11;
  localparam int IR_CLR  = 1 << 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] ctl = '0;
  logic [3:0]  opcode;
  logic        zero;
  logic        carry;
  logic [3:0]  acc_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int m_acc = 0;
  int m_z   = 0;
  int m_c   = 0;

  always #10 clk = ~clk;

  acc4_datapath u_dut (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .opcode  (opcode),
    .zero    (zero),
    .carry   (carry),
    .acc_out (acc_out)
  );

  function automatic int rw(int i);
    return (7 * (i % 16) + 3) % 16;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(int c);
    @(negedge clk);
    ctl = 13'(c);
    @(posedge clk);
    @(negedge clk);
    ctl = '0;
  endtask

  task automatic goto_pc(int p);
    step(PC_CLR);
    for (int k = 0; k < p; k++) step(PC_INC);
  endtask

  task automatic chk_acc(string req);
    chk(req, int'(acc_out), m_acc);
    chk(req, int'(zero), m_z);
    chk(req, int'(carry), m_c);
  endtask

  // execute ALU op with operand register pointing at rw(p)
  task automatic do_op(int p, int op);
    int m;
    int s;
    goto_pc(p);
    step(OPR_LD);
    m = rw(rw(p));
    s = m_acc;
    case (op)
      0: s = m;
      1: begin s = m_acc + m;            m_c = (s > 15); end
      2: begin s = m_acc + (15 - m) + 1; m_c = (s > 15); end
      3: s = m_acc & m;
      4: s = 15 - m_acc;
      5: begin s = m_acc + 1;            m_c = (s > 15); end
      6: begin s = m_acc + 15;           m_c = (s > 15); end
      default: s = m_acc;
    endcase
    m_acc = s % 16;
    m_z   = (m_acc == 0);
    step(ADR_SEL | ACC_WE | (op << 6));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", int'(acc_out), 0);
    chk("R1", int'(zero), 0);
    chk("R1", int'(carry), 0);
    chk("R1", int'(opcode), 0);

    // R2/R3 fetch walk across wrap
    step(PC_CLR);
    for (int i = 0; i < 18; i++) begin
      step(IR_LD | PC_INC);
      chk("R2", int'(opcode), rw(i));
    end
    step(IR_LD | IR_CLR);
    chk("R2", int'(opcode), 0);
    step(0);
    chk("R2", int'(opcode), 0);

    // R3 jump load and priority
    for (int p = 0; p < 16; p++) begin
      goto_pc(p);
      step(OPR_LD);
      step(PC_LD | PC_INC);
      step(IR_LD);
      chk("R3", int'(opcode), rw(rw(p)));
    end
    step(PC_CLR | PC_LD | PC_INC);
    step(IR_LD);
    chk("R3", int'(opcode), rw(0));

    // R4/R5/R6/R7 exhaustive binary sweeps
    for (int op = 1; op <= 3; op++) begin
      for (int pa = 0; pa < 16; pa++) begin
        for (int pm = 0; pm < 16; pm++) begin
          do_op(pa, 0);
          chk("R4", int'(acc_out), m_acc);
          chk("R4", int'(carry), m_c);
          do_op(pm, op);
          case (op)
            1: chk_acc("R5");
            2: chk_acc("R6");
            default: chk_acc("R7");
          endcase
        end
      end
    end

    // R7/R8/R9 unary sweeps
    for (int op = 4; op <= 7; op++) begin
      for (int pa = 0; pa < 16; pa++) begin
        do_op(pa, 0);
        do_op(pa, op);
        if (op == 5 || op == 6) chk_acc("R8");
        else chk_acc("R7");
        chk("R9", int'(zero), m_z);
      end
    end

    // R10 hold with unrelated activity
    do_op(3, 0);
    step(IR_LD | PC_INC | OPR_LD);
    chk_acc("R10");
    step(ADR_SEL | (1 << 6));
    chk_acc("R10");

    // R11 clears
    do_op(0, 0);
    m_c = 1;
    m_acc = 15;
    step(PC_CLR);
    // force carry=1: load 15 then increment
    for (int p = 0; p < 16; p++) if (rw(rw(p)) == 15) begin do_op(p, 0); do_op(p, 5); end
    chk("R8", int'(carry), 1);
    step(ACC_CLR | ACC_WE | (5 << 6));
    m_acc = 0; m_z = 1;
    chk_acc("R11");
    step(FLG_CLR);
    m_z = 0; m_c = 0;
    chk_acc("R11");
    for (int p = 0; p < 16; p++) if (rw(rw(p)) == 9) do_op(p, 0);
    step(ACC_CLR | FLG_CLR);
    m_acc = 0; m_z = 0; m_c = 0;
    chk_acc("R11");

    // R1 reset again mid-run
    do_op(5, 0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", int'(acc_out), 0);
    chk("R1", int'(zero), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule